// File: doc/BRIEF.md
# BCD Calendar Clock with Frozen Host View

This block is a calendar clock that counts hundredths of seconds, seconds, minutes, hours, weekday, day of month, month and two-digit year, all held in BCD. The host system supplies a one-cycle 100 Hz enable and a one-cycle 2048 Hz enable, both derived from its own clock. The clock keeps two copies of the time. The running copy advances on every 100 Hz enable. The host copy is what a byte-wide register port reads and writes, at addresses 0x0 to 0xA, with a control byte at 0xB.

The running copy advances seconds and every higher field on the tick that moves hundredths from 98 to 99. The host copy takes those higher fields only on the tick that wraps hundredths from 99 to 00. Software can clear a transfer-enable bit to freeze the host copy while it reads or writes a consistent set of fields. The running copy keeps counting during the freeze, so no time is lost.

The month byte also carries two controls: an oscillator-halt bit that stops all counting, and a square-wave disable bit for a 1024 Hz, 50% duty output.

Top module: `rtc_core`

## Requirements
- R1: After reset the host copy reads time 00:00:00.00 in 24-hour mode, weekday 01, date 01, month byte 0xC1 (halt bit 7 = 1, square-wave disable bit 6 = 1, month 01), year 00. The control byte at 0xB reads 0x80 (transfer enable, bit 7 = 1).
- R2: Field addresses are: hundredths 0x0, seconds 0x1, minutes 0x2, hours 0x4, weekday 0x6, date 0x8, month 0x9, year 0xA. Each 100 Hz enable adds one hundredth in BCD. Seconds and minutes wrap 59 to 00 and carry. In 24-hour mode hours wrap 23 to 00 and carry into the date.
- R3: On the enable that takes hundredths from 98 to 99, the host copy shows hundredths 99 with the seconds and higher fields still at their old values. Those fields appear together with hundredths 00 on the next enable.
- R4: Date 31 wraps to 01 in months 01, 03, 05, 07, 08, 10 and 12. Date 30 wraps in months 04, 06, 09 and 11. In February date 28 wraps in years not divisible by 4, and date 29 wraps in years divisible by 4 (00 counts as leap). Month 12 wraps to 01 and carries into the year. Year 99 wraps to 00.
- R5: Hours bit 6 = 1 selects 12-hour mode, in which bit 5 = 1 means PM and bits 4:0 hold the BCD hour. The sequence is 11 AM → 12 PM → 01 PM, and 11 PM → 12 AM. The date advances only at 11 PM → 12 AM. In 24-hour mode bit 5 is the tens bit for hours 20 to 23.
- R6: The weekday counts 1 to 7 and wraps from 7 to 1 when the date advances.
- R7: Bits with no meaning read 0 whatever is written. Read masks: seconds and minutes 0x7F, hours 0x7F, weekday 0x07, date 0x3F, month 0xDF, control 0x80. Addresses 0x3, 0x5, 0x7 and 0xC to 0xF read 0x00 and ignore writes.
- R8: While month bit 7 is 1 the 100 Hz enable has no effect and the square wave does not toggle.
- R9: While control bit 7 is 0 the host copy holds still and the running copy keeps counting. The first 100 Hz enable after the bit returns to 1 shows the running time, with nothing lost.
- R10: A host write to a time field sets that field in both copies, so counting on the next enable continues from the written value.
- R11: The square-wave output enable is the inverse of month bit 6. While the clock runs, the square-wave level inverts on every 2048 Hz enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_100hz | input | 1 | One-cycle enable at 100 Hz |
| tick_2048hz | input | 1 | One-cycle enable at 2048 Hz |
| reg_addr | input | ADDR_W | Register address |
| reg_wr | input | 1 | Write strobe, one cycle per byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| sqw_out | output | 1 | 1024 Hz square-wave level |
| sqw_oe | output | 1 | Square-wave drive enable (0 means high-impedance) |

## Verification
The counting chain is driven from times placed just before a boundary: end of day in 24-hour mode, 11 AM and 11 PM in 12-hour mode, and the last date of a 31-day month, a 30-day month, February in a leap year and February in a common year, plus the last day of year 99. Each case separates a wrong carry from a wrong wrap value. Reading between the 98→99 and 99→00 ticks shows whether the host copy leaks the advanced seconds early. A long run with the transfer bit cleared shows whether the host copy stays still and the running copy keeps time. Writes with all bits set show whether the masks are wrong and whether unused addresses are decoded.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int RA_HUND  = 0;
    localparam int RA_SEC   = 1;
    localparam int RA_MIN   = 2;
    localparam int RA_HOUR  = 4;
    localparam int RA_DOW   = 6;
    localparam int RA_DATE  = 8;
    localparam int RA_MONTH = 9;
    localparam int RA_YEAR  = 10;
    localparam int RA_CTRL  = 11;

    typedef struct packed {
        logic [7:0] hund;
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hour;
        logic [7:0] dow;
        logic [7:0] date;
        logic [7:0] month;
        logic [7:0] year;
    } rtc_time_t;

    typedef struct packed {
        rtc_time_t in_t;     // running copy
        rtc_time_t ex_t;     // host-visible copy
        logic      halt;     // oscillator stopped
        logic      sq_off;   // square wave disabled
        logic      xfer_en;  // host copy follows running copy
    } core_st_t;

    localparam rtc_time_t TIME_RST = '{hund: 8'h00, sec: 8'h00, min: 8'h00, hour: 8'h00,
                                       dow: 8'h01, date: 8'h01, month: 8'h01, year: 8'h00};

    localparam core_st_t CORE_RST = '{in_t: TIME_RST, ex_t: TIME_RST,
                                      halt: 1'b1, sq_off: 1'b1, xfer_en: 1'b1};

    // Add one to a two-digit BCD value (no wrap handling).
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return {v[7:4], v[3:0] + 4'd1};
    endfunction

    // Last valid date of a month, in BCD.
    function automatic logic [7:0] month_last(input logic [7:0] mon, input logic [7:0] yr);
        logic [4:0] mod_sum;
        mod_sum = {yr[7:4], 1'b0} + {1'b0, yr[3:0]};  // 10*t+u == 2*t+u (mod 4)
        case (mon[4:0])
            5'h02:                      return (mod_sum[1:0] == 2'b00) ? 8'h29 : 8'h28;
            5'h04, 5'h06, 5'h09, 5'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_advance.sv
// Combinational one-second step of the calendar (hundredths untouched).
module rtc_advance
    import rtc_pkg::*;
(
    input  rtc_time_t cur_i,
    output rtc_time_t nxt_o
);

    logic       c_min, c_hour, c_day, c_mon, c_year;
    logic [7:0] h_inc;
    logic [7:0] last_d;

    always_comb begin
        nxt_o  = cur_i;
        c_min  = 1'b0;
        c_hour = 1'b0;
        c_day  = 1'b0;
        c_mon  = 1'b0;
        c_year = 1'b0;
        h_inc  = 8'h00;
        last_d = month_last(cur_i.month, cur_i.year);

        if (cur_i.sec == 8'h59) begin
            nxt_o.sec = 8'h00;
            c_min     = 1'b1;
        end else begin
            nxt_o.sec = bcd_inc(cur_i.sec);
        end

        if (c_min) begin
            if (cur_i.min == 8'h59) begin
                nxt_o.min = 8'h00;
                c_hour    = 1'b1;
            end else begin
                nxt_o.min = bcd_inc(cur_i.min);
            end
        end

        if (c_hour) begin
            if (!cur_i.hour[6]) begin
                h_inc = bcd_inc({2'b00, cur_i.hour[5:0]});
                if (cur_i.hour[5:0] == 6'h23) begin
                    nxt_o.hour[5:0] = 6'h00;
                    c_day           = 1'b1;
                end else begin
                    nxt_o.hour[5:0] = h_inc[5:0];
                end
            end else begin
                h_inc = bcd_inc({3'b000, cur_i.hour[4:0]});
                if (cur_i.hour[4:0] == 5'h11) begin
                    nxt_o.hour[4:0] = 5'h12;
                    nxt_o.hour[5]   = ~cur_i.hour[5];
                    c_day           = cur_i.hour[5];
                end else if (cur_i.hour[4:0] == 5'h12) begin
                    nxt_o.hour[4:0] = 5'h01;
                end else begin
                    nxt_o.hour[4:0] = h_inc[4:0];
                end
            end
        end

        if (c_day) begin
            nxt_o.dow = (cur_i.dow == 8'h07) ? 8'h01 : cur_i.dow + 8'd1;
            if (cur_i.date == last_d) begin
                nxt_o.date = 8'h01;
                c_mon      = 1'b1;
            end else begin
                nxt_o.date = bcd_inc(cur_i.date);
            end
        end

        if (c_mon) begin
            if (cur_i.month[4:0] == 5'h12) begin
                nxt_o.month = 8'h01;
                c_year      = 1'b1;
            end else begin
                nxt_o.month = bcd_inc(cur_i.month);
            end
        end

        if (c_year) begin
            nxt_o.year = (cur_i.year == 8'h99) ? 8'h00 : bcd_inc(cur_i.year);
        end
    end

endmodule

// File: rtl/rtc_sqw.sv
// Square-wave toggle driven by a 2048 Hz enable.
module rtc_sqw (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic run_i,
    output logic sqw_o
);

    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_q;
        if (tick_i && run_i) lvl_d = ~lvl_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign sqw_o = lvl_q;

endmodule

// File: rtl/rtc_rdmux.sv
// Read selection of the host-visible copy.
module rtc_rdmux
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  rtc_time_t         ext_i,
    input  logic              halt_i,
    input  logic              sq_off_i,
    input  logic              xfer_en_i,
    output logic [7:0]        rdata_o
);

    localparam logic [ADDR_W-1:0] A_HUND  = ADDR_W'(RA_HUND);
    localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(RA_SEC);
    localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(RA_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(RA_HOUR);
    localparam logic [ADDR_W-1:0] A_DOW   = ADDR_W'(RA_DOW);
    localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(RA_DATE);
    localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(RA_MONTH);
    localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(RA_YEAR);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(RA_CTRL);

    always_comb begin
        case (addr_i)
            A_HUND:  rdata_o = ext_i.hund;
            A_SEC:   rdata_o = ext_i.sec;
            A_MIN:   rdata_o = ext_i.min;
            A_HOUR:  rdata_o = ext_i.hour;
            A_DOW:   rdata_o = ext_i.dow;
            A_DATE:  rdata_o = ext_i.date;
            A_MONTH: rdata_o = {halt_i, sq_off_i, 1'b0, ext_i.month[4:0]};
            A_YEAR:  rdata_o = ext_i.year;
            A_CTRL:  rdata_o = {xfer_en_i, 7'b0};
            default: rdata_o = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_core.sv
module rtc_core
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              tick_2048hz,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              sqw_out,
    output logic              sqw_oe
);

    localparam logic [ADDR_W-1:0] A_HUND  = ADDR_W'(RA_HUND);
    localparam logic [ADDR_W-1:0] A_SEC   = ADDR_W'(RA_SEC);
    localparam logic [ADDR_W-1:0] A_MIN   = ADDR_W'(RA_MIN);
    localparam logic [ADDR_W-1:0] A_HOUR  = ADDR_W'(RA_HOUR);
    localparam logic [ADDR_W-1:0] A_DOW   = ADDR_W'(RA_DOW);
    localparam logic [ADDR_W-1:0] A_DATE  = ADDR_W'(RA_DATE);
    localparam logic [ADDR_W-1:0] A_MONTH = ADDR_W'(RA_MONTH);
    localparam logic [ADDR_W-1:0] A_YEAR  = ADDR_W'(RA_YEAR);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(RA_CTRL);

    core_st_t  st_d, st_q;
    rtc_time_t adv_t;

    // Observation points for the bound checker.
    logic       osc_halt;
    logic       host_xfer;
    logic [7:0] run_hund;
    logic [7:0] host_hund;
    logic [7:0] host_sec;
    logic [63:0] host_flat;

    rtc_advance u_adv (
        .cur_i (st_q.in_t),
        .nxt_o (adv_t)
    );

    always_comb begin
        st_d = st_q;

        if (tick_100hz && !st_q.halt) begin
            if (st_q.in_t.hund == 8'h98) begin
                st_d.in_t      = adv_t;
                st_d.in_t.hund = 8'h99;
            end else if (st_q.in_t.hund == 8'h99) begin
                st_d.in_t.hund = 8'h00;
            end else begin
                st_d.in_t.hund = bcd_inc(st_q.in_t.hund);
            end

            if (st_q.xfer_en) begin
                if (st_d.in_t.hund == 8'h99) st_d.ex_t.hund = 8'h99;
                else                         st_d.ex_t      = st_d.in_t;
            end
        end

        if (reg_wr) begin
            case (reg_addr)
                A_HUND: begin
                    st_d.in_t.hund = reg_wdata;
                    st_d.ex_t.hund = reg_wdata;
                end
                A_SEC: begin
                    st_d.in_t.sec = reg_wdata & 8'h7F;
                    st_d.ex_t.sec = reg_wdata & 8'h7F;
                end
                A_MIN: begin
                    st_d.in_t.min = reg_wdata & 8'h7F;
                    st_d.ex_t.min = reg_wdata & 8'h7F;
                end
                A_HOUR: begin
                    st_d.in_t.hour = reg_wdata & 8'h7F;
                    st_d.ex_t.hour = reg_wdata & 8'h7F;
                end
                A_DOW: begin
                    st_d.in_t.dow = reg_wdata & 8'h07;
                    st_d.ex_t.dow = reg_wdata & 8'h07;
                end
                A_DATE: begin
                    st_d.in_t.date = reg_wdata & 8'h3F;
                    st_d.ex_t.date = reg_wdata & 8'h3F;
                end
                A_MONTH: begin
                    st_d.in_t.month = {3'b000, reg_wdata[4:0]};
                    st_d.ex_t.month = {3'b000, reg_wdata[4:0]};
                    st_d.halt       = reg_wdata[7];
                    st_d.sq_off     = reg_wdata[6];
                end
                A_YEAR: begin
                    st_d.in_t.year = reg_wdata;
                    st_d.ex_t.year = reg_wdata;
                end
                A_CTRL: begin
                    st_d.xfer_en = reg_wdata[7];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= CORE_RST;
        else        st_q <= st_d;
    end

    rtc_rdmux #(.ADDR_W(ADDR_W)) u_rd (
        .addr_i    (reg_addr),
        .ext_i     (st_q.ex_t),
        .halt_i    (st_q.halt),
        .sq_off_i  (st_q.sq_off),
        .xfer_en_i (st_q.xfer_en),
        .rdata_o   (reg_rdata)
    );

    rtc_sqw u_sqw (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick_2048hz),
        .run_i  (!st_q.halt),
        .sqw_o  (sqw_out)
    );

    assign sqw_oe    = !st_q.sq_off;
    assign osc_halt  = st_q.halt;
    assign host_xfer = st_q.xfer_en;
    assign run_hund  = st_q.in_t.hund;
    assign host_hund = st_q.ex_t.hund;
    assign host_sec  = st_q.ex_t.sec;
    assign host_flat = st_q.ex_t;

endmodule

// File: rtl/rtc_core_chk.sv
module rtc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        tick_100hz,
    input logic        tick_2048hz,
    input logic        reg_wr,
    input logic        osc_halt,
    input logic        host_xfer,
    input logic [7:0]  run_hund,
    input logic [7:0]  host_sec,
    input logic [63:0] host_flat,
    input logic        sqw_out
);

    // R8: halted oscillator keeps the running hundredths still
    a_r8_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (osc_halt && !reg_wr) |=> $stable(run_hund));

    // R9: frozen host copy does not move without a write
    a_r9_freeze_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_xfer && !reg_wr) |=> $stable(host_flat));

    // R3: host seconds stay put on the 98->99 step
    a_r3_sec_waits: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz && run_hund == 8'h98 && !reg_wr) |=> $stable(host_sec));

    // R2: hundredths wrap from 99 to 00
    a_r2_hund_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_100hz && !osc_halt && run_hund == 8'h99 && !reg_wr) |=> (run_hund == 8'h00));

    // R11: square wave inverts on each 2048 Hz enable while running
    a_r11_sqw_flip: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_2048hz && !osc_halt) |=> (sqw_out != $past(sqw_out)));

endmodule

bind rtc_core rtc_core_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_100hz  (tick_100hz),
    .tick_2048hz (tick_2048hz),
    .reg_wr      (reg_wr),
    .osc_halt    (osc_halt),
    .host_xfer   (host_xfer),
    .run_hund    (run_hund),
    .host_sec    (host_sec),
    .host_flat   (host_flat),
    .sqw_out     (sqw_out)
);

// File: tb/sim_rtc_core.sv
`timescale 1ns/1ps
module sim_rtc_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       tick_2048hz = 1'b0;
    logic [3:0] reg_addr = 4'h0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sqw_out;
    logic       sqw_oe;

    int n_run = 0;
    int n_fail = 0;

    logic [7:0] exp_q[$];
    logic [3:0] adr_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    rtc_core #(.ADDR_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .tick_100hz(tick_100hz), .tick_2048hz(tick_2048hz),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sqw_out(sqw_out), .sqw_oe(sqw_oe)
    );

    // Monitor: pops expected reads and compares after the edge settles.
    initial forever begin
        @(posedge clk);
        #1;
        while (exp_q.size() > 0) begin
            logic [7:0] e;
            logic [3:0] a;
            string      t;
            e = exp_q.pop_front();
            a = adr_q.pop_front();
            t = tag_q.pop_front();
            n_run++;
            if (reg_rdata !== e) begin
                n_fail++;
                $display("FAIL %s addr %0h: got %02h expected %02h", t, a, reg_rdata, e);
            end
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        reg_addr = a;
        exp_q.push_back(e);
        adr_q.push_back(a);
        tag_q.push_back(t);
        @(negedge clk);
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_100hz = 1'b1;
            @(negedge clk);
            tick_100hz = 1'b0;
        end
    endtask

    task automatic pulse2048();
        @(negedge clk);
        tick_2048hz = 1'b1;
        @(negedge clk);
        tick_2048hz = 1'b0;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        n_run++;
        if (act !== e) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", t, act, e);
        end
    endtask

    task automatic set_eod(input logic [7:0] hr);
        wr(4'h4, hr);
        wr(4'h2, 8'h59);
        wr(4'h1, 8'h59);
        wr(4'h0, 8'h98);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(4'h0, 8'h00, "R1"); rd(4'h1, 8'h00, "R1"); rd(4'h4, 8'h00, "R1");
        rd(4'h6, 8'h01, "R1"); rd(4'h8, 8'h01, "R1"); rd(4'h9, 8'hC1, "R1");
        rd(4'hA, 8'h00, "R1"); rd(4'hB, 8'h80, "R1");
        chk_bit(sqw_oe, 1'b0, "R1 sqw_oe");

        // R8 halted: ticks ignored
        tick(5);
        rd(4'h0, 8'h00, "R8");

        // start the clock, square wave on
        wr(4'h9, 8'h01);
        rd(4'h9, 8'h01, "R7");
        chk_bit(sqw_oe, 1'b1, "R11 oe");

        // common-year February end of day, weekday 7
        wr(4'hA, 8'h23); wr(4'h9, 8'h02); wr(4'h8, 8'h28); wr(4'h6, 8'h07);
        set_eod(8'h23);
        tick(1);
        rd(4'h0, 8'h99, "R3"); rd(4'h1, 8'h59, "R3"); rd(4'h6, 8'h07, "R3");
        tick(1);
        rd(4'h0, 8'h00, "R2"); rd(4'h1, 8'h00, "R2"); rd(4'h2, 8'h00, "R2");
        rd(4'h4, 8'h00, "R2"); rd(4'h6, 8'h01, "R6");
        rd(4'h8, 8'h01, "R4"); rd(4'h9, 8'h03, "R4"); rd(4'hA, 8'h23, "R4");

        // leap February
        wr(4'hA, 8'h24); wr(4'h9, 8'h02); wr(4'h8, 8'h28);
        set_eod(8'h23); tick(2);
        rd(4'h8, 8'h29, "R4"); rd(4'h9, 8'h02, "R4");
        set_eod(8'h23); tick(2);
        rd(4'h8, 8'h01, "R4"); rd(4'h9, 8'h03, "R4");

        // 30-day month
        wr(4'h9, 8'h04); wr(4'h8, 8'h30);
        set_eod(8'h23); tick(2);
        rd(4'h8, 8'h01, "R4"); rd(4'h9, 8'h05, "R4");

        // year wrap
        wr(4'hA, 8'h99); wr(4'h9, 8'h12); wr(4'h8, 8'h31);
        set_eod(8'h23); tick(2);
        rd(4'h8, 8'h01, "R4"); rd(4'h9, 8'h01, "R4"); rd(4'hA, 8'h00, "R4");

        // R5 12-hour mode
        set_eod(8'h51); tick(2);
        rd(4'h4, 8'h72, "R5"); rd(4'h8, 8'h01, "R5");
        set_eod(8'h71); tick(2);
        rd(4'h4, 8'h52, "R5"); rd(4'h8, 8'h02, "R5");
        set_eod(8'h52); tick(2);
        rd(4'h4, 8'h41, "R5"); rd(4'h8, 8'h02, "R5");

        // R10 write lands in the running copy
        wr(4'h1, 8'h30); wr(4'h0, 8'h10);
        tick(1);
        rd(4'h0, 8'h11, "R10"); rd(4'h1, 8'h30, "R10");

        // R9 freeze
        wr(4'h0, 8'h00); wr(4'h1, 8'h00); wr(4'h2, 8'h00);
        wr(4'hB, 8'h00);
        rd(4'hB, 8'h00, "R9");
        tick(150);
        rd(4'h0, 8'h00, "R9"); rd(4'h1, 8'h00, "R9");
        wr(4'hB, 8'h80);
        tick(1);
        rd(4'h0, 8'h51, "R9"); rd(4'h1, 8'h01, "R9");

        // R7 masks and unused addresses
        wr(4'h1, 8'hD9); rd(4'h1, 8'h59, "R7");
        wr(4'h6, 8'hFF); rd(4'h6, 8'h07, "R7");
        wr(4'h8, 8'hFF); rd(4'h8, 8'h3F, "R7");
        wr(4'h3, 8'h55); rd(4'h3, 8'h00, "R7");
        wr(4'hC, 8'h12); rd(4'hC, 8'h00, "R7");
        wr(4'hB, 8'h7F); rd(4'hB, 8'h00, "R7");
        wr(4'hB, 8'h80);

        // R11 square wave toggles
        for (int i = 0; i < 4; i++) begin
            prev = sqw_out;
            pulse2048();
            chk_bit(sqw_out, ~prev, "R11 toggle");
        end

        // R8 halted square wave holds
        wr(4'h9, 8'h85);
        prev = sqw_out;
        pulse2048();
        chk_bit(sqw_out, prev, "R8 sqw hold");
        rd(4'h9, 8'h85, "R8");

        // R11 disable
        wr(4'h9, 8'h41);
        chk_bit(sqw_oe, 1'b0, "R11 oe off");
        rd(4'h9, 8'h41, "R11");

        repeat (3) @(negedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule